// File: doc/BRIEF.md
# H-Bridge Channel Control and Fault Latch

This block is the digital control core of a single H-bridge channel. Two polarity inputs each command one half-bridge. An active-high disable input switches both outputs off. An active-high enable input also acts as a second disable, and holding it low puts the channel to sleep. The block also takes digital fault indications from the analog front end: short-circuit, over-temperature (with a separate flag saying the die has cooled below the hysteresis point), supply under-voltage, and an off-request from the current regulator. It drives a high-side and a low-side switch enable for each half-bridge, and an active-low status flag.

Short-circuit and over-temperature are hard faults. Either one latches the bridge off and pulls the flag low. The latch is released only by a release edge on the control inputs: disable going low, or enable going high. Under-voltage is not latched and recovers on its own. Sleep never shows a fault. After reset, the outputs stay off for a power-on delay. Every change of polarity on a half-bridge passes through a dead gap in which both of its switches are off.

Top module: `hbridge_ctrl`

## Requirements
- R1: With enable=1, disable=0 and no fault, polarity input 1 turns on only that half's high-side enable, and polarity input 0 turns on only its low-side enable.
- R2: Both polarities 0 turns on both low-side enables, and both polarities 1 turns on both high-side enables. In both cases the flag (flag_n) stays 1.
- R3: With enable=1 and disable=1, all four switch enables are 0 and flag_n is 0.
- R4: With enable=0, all four switch enables are 0 and flag_n is 1, whatever the disable input is, unless a hard fault is latched.
- R5: A short-circuit or over-temperature indication latches all switches off and flag_n at 0, and the latch stays set after the indication goes away.
- R6: The latch is released only by a 1-to-0 change of disable or a 0-to-1 change of enable. Polarity activity leaves it set.
- R7: A latched over-temperature is released by a release edge only while the cooled flag is 1. A release edge with the cooled flag at 0 leaves the latch set.
- R8: Under-voltage turns all switches off and sets flag_n to 0 while enabled. When it goes away, the flag returns to 1 and the outputs resume the commanded state without any release edge.
- R9: For POD_CYCLES clock cycles after reset is released, all switch enables stay 0.
- R10: The high-side and low-side enables of one half are never both 1. On a polarity change, both are 0 for exactly BBM_CYCLES clock cycles.
- R11: The regulator off-request forces all four switches off. It leaves flag_n unchanged and neither sets nor clears the fault latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_a | input | 1 | Polarity command, half-bridge A (1 = to supply) |
| pol_b | input | 1 | Polarity command, half-bridge B (1 = to supply) |
| dis | input | 1 | Disable, active high |
| en | input | 1 | Enable; low = outputs off and sleep |
| uv_flt | input | 1 | Supply under-voltage indication |
| ot_flt | input | 1 | Over-temperature indication |
| ot_cool | input | 1 | Temperature below threshold minus hysteresis |
| sc_flt | input | 1 | Short-circuit indication |
| reg_off | input | 1 | Current-regulator off-request |
| hs_a | output | 1 | High-side switch enable, half A |
| ls_a | output | 1 | Low-side switch enable, half A |
| hs_b | output | 1 | High-side switch enable, half B |
| ls_b | output | 1 | Low-side switch enable, half B |
| flag_n | output | 1 | Status flag, active low |

## Verification
Directed vectors cover each row of the truth table: single-side drive in both directions, the two freewheel patterns, disable, and sleep. Comparing sleep with disable tells apart the two off states, which differ only in the flag. Fault sequences separate a latched fault from a self-recovering one. They also separate a genuine release edge from plain polarity activity, and a release edge with the cooled flag at 0 from one with it at 1. Random vectors with rare faults then mix input changes, including simultaneous release edges and fault assertions, against a bench model of the latch. A timed polarity flip measures the dead gap cycle by cycle.

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl #(
  parameter int POD_CYCLES = 50000,
  parameter int BBM_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pol_a,
  input  logic pol_b,
  input  logic dis,
  input  logic en,
  input  logic uv_flt,
  input  logic ot_flt,
  input  logic ot_cool,
  input  logic sc_flt,
  input  logic reg_off,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b,
  output logic flag_n
);
  localparam int PW = $clog2(POD_CYCLES + 1);
  localparam int GW = (BBM_CYCLES < 1) ? 1 : $clog2(BBM_CYCLES + 1);
  localparam logic [8:0] SYNC_INIT = 9'b1_1_1_0_0_0_0_0_0;

  logic [8:0] raw, s1, s2;
  logic pol_a_s, pol_b_s, dis_s, en_s, uv_s, ot_s, cool_s, sc_s, roff_s;

  assign raw = {pol_a, pol_b, dis, en, uv_flt, ot_flt, ot_cool, sc_flt, reg_off};
  assign {pol_a_s, pol_b_s, dis_s, en_s, uv_s, ot_s, cool_s, sc_s, roff_s} = s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= SYNC_INIT;
      s2 <= SYNC_INIT;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  logic dis_d, en_d, release_ev;
  logic sc_lat, ot_lat, flt_lat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dis_d <= 1'b1;
      en_d  <= 1'b0;
    end else begin
      dis_d <= dis_s;
      en_d  <= en_s;
    end

  assign release_ev = (dis_d & ~dis_s) | (~en_d & en_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sc_lat <= 1'b0;
      ot_lat <= 1'b0;
    end else begin
      if (sc_s) sc_lat <= 1'b1;
      else if (release_ev) sc_lat <= 1'b0;
      if (ot_s) ot_lat <= 1'b1;
      else if (release_ev && cool_s) ot_lat <= 1'b0;
    end

  assign flt_lat = sc_lat | ot_lat;

  logic [PW-1:0] por_cnt;
  logic por_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) por_cnt <= '0;
    else if (!por_done) por_cnt <= por_cnt + 1'b1;

  assign por_done = (por_cnt == PW'(POD_CYCLES));

  logic drive;
  assign drive = por_done & en_s & ~dis_s & ~uv_s & ~flt_lat & ~roff_s;

  logic [1:0] pol_s, hs, ls;
  assign pol_s = {pol_b_s, pol_a_s};

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic side;
    logic [GW-1:0] gap;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        side <= 1'b1;
        gap  <= '0;
      end else if (pol_s[h] != side) begin
        side <= pol_s[h];
        gap  <= GW'(BBM_CYCLES);
      end else if (gap != '0) begin
        gap <= gap - 1'b1;
      end

    assign hs[h] = drive & (gap == '0) & side;
    assign ls[h] = drive & (gap == '0) & ~side;
  end

  assign hs_a = hs[0];
  assign ls_a = ls[0];
  assign hs_b = hs[1];
  assign ls_b = ls[1];
  assign flag_n = ~(flt_lat | (en_s & (dis_s | uv_s)));
endmodule

// File: rtl/hbridge_ctrl_chk.sv
module hbridge_ctrl_chk #(
  parameter int BBM_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b,
  input logic flag_n,
  input logic sc_s,
  input logic ot_s,
  input logic flt_lat,
  input logic roff_s,
  input logic por_done,
  input logic en_s,
  input logic dis_s
);
  logic any_on;
  assign any_on = hs_a | ls_a | hs_b | ls_b;

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a) && !(hs_b && ls_b));

  if (BBM_CYCLES > 0) begin : g_gap
    a_r10_gap_a_hl: assert property (@(posedge clk) disable iff (!rst_n) hs_a |=> !ls_a);
    a_r10_gap_a_lh: assert property (@(posedge clk) disable iff (!rst_n) ls_a |=> !hs_a);
    a_r10_gap_b_hl: assert property (@(posedge clk) disable iff (!rst_n) hs_b |=> !ls_b);
    a_r10_gap_b_lh: assert property (@(posedge clk) disable iff (!rst_n) ls_b |=> !hs_b);
  end

  a_r5_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_s || ot_s) |=> !flag_n);

  a_r5_latched_off: assert property (@(posedge clk) disable iff (!rst_n)
    flt_lat |-> !any_on);

  a_r11_regoff: assert property (@(posedge clk) disable iff (!rst_n)
    roff_s |-> !any_on);

  a_r9_pod_off: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |-> !any_on);

  a_r4_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !flt_lat) |-> (flag_n && !any_on));

  a_r3_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && dis_s) |-> (!flag_n && !any_on));
endmodule

bind hbridge_ctrl hbridge_ctrl_chk #(.BBM_CYCLES(BBM_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b), .flag_n(flag_n),
  .sc_s(sc_s), .ot_s(ot_s), .flt_lat(flt_lat), .roff_s(roff_s),
  .por_done(por_done), .en_s(en_s), .dis_s(dis_s)
);

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;
  localparam int POD = 40;
  localparam int BBM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_a = 1'b1, pol_b = 1'b1, dis = 1'b1, en = 1'b0;
  logic uv_flt = 1'b0, ot_flt = 1'b0, ot_cool = 1'b0, sc_flt = 1'b0, reg_off = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b, flag_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic m_sc = 1'b0, m_ot = 1'b0;

  always #10 clk = ~clk;

  hbridge_ctrl #(.POD_CYCLES(POD), .BBM_CYCLES(BBM)) i_hbridge_ctrl (
    .clk(clk), .rst_n(rst_n), .pol_a(pol_a), .pol_b(pol_b), .dis(dis), .en(en),
    .uv_flt(uv_flt), .ot_flt(ot_flt), .ot_cool(ot_cool), .sc_flt(sc_flt),
    .reg_off(reg_off), .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b),
    .flag_n(flag_n)
  );

  function automatic logic [4:0] expect_out(logic pa, logic pb, logic d, logic e,
                                            logic uv, logic ro, logic lat);
    logic drv;
    drv = e & ~d & ~uv & ~lat & ~ro;
    return {drv & pa, drv & ~pa, drv & pb, drv & ~pb, ~(lat | (e & (d | uv)))};
  endfunction

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {hs_a,ls_a,hs_b,ls_b,flag_n} = %b, expected %b", req, act, exp);
    end
  endtask

  task automatic apply(logic pa, logic pb, logic d, logic e, logic uv, logic ot,
                       logic cool, logic sc, logic ro, string req);
    logic rel;
    rel = (dis & ~d) | (~en & e);
    m_sc = sc | (m_sc & ~rel);
    m_ot = ot | (m_ot & ~(rel & cool));
    @(negedge clk);
    pol_a = pa; pol_b = pb; dis = d; en = e; uv_flt = uv;
    ot_flt = ot; ot_cool = cool; sc_flt = sc; reg_off = ro;
    repeat (12) @(negedge clk);
    check(req, {hs_a, ls_a, hs_b, ls_b, flag_n},
          expect_out(pa, pb, d, e, uv, ro, m_sc | m_ot));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int offs;
    logic seen;
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    // R4 reset state: sleep, no fault shown
    check("R4 reset", {hs_a, ls_a, hs_b, ls_b, flag_n}, 5'b00001);
    dis = 1'b0; en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (POD / 2) @(negedge clk);
    check("R9 pod", {hs_a, ls_a, hs_b, ls_b, flag_n}, 5'b00001);
    repeat (POD) @(negedge clk);
    check("R2 hs freewheel after pod", {hs_a, ls_a, hs_b, ls_b, flag_n}, 5'b10101);

    apply(1,0,0,1,0,0,0,0,0,"R1");
    apply(0,1,0,1,0,0,0,0,0,"R1");
    apply(0,0,0,1,0,0,0,0,0,"R2");
    apply(1,1,0,1,0,0,0,0,0,"R2");
    apply(1,0,1,1,0,0,0,0,0,"R3");
    apply(1,0,1,0,0,0,0,0,0,"R4");
    apply(1,0,0,0,0,0,0,0,0,"R4");
    apply(1,0,0,1,0,0,0,0,0,"R1");
    apply(1,0,0,1,0,0,0,1,0,"R5");
    apply(1,0,0,1,0,0,0,0,0,"R5");
    apply(0,1,0,1,0,0,0,0,0,"R6");
    apply(0,0,0,0,0,0,0,0,0,"R6");
    apply(0,0,0,1,0,0,0,0,0,"R6");
    apply(1,0,0,1,0,1,0,0,0,"R5");
    apply(1,0,0,1,0,0,0,0,0,"R7");
    apply(1,0,1,1,0,0,0,0,0,"R7");
    apply(1,0,0,1,0,0,0,0,0,"R7");
    apply(1,0,1,1,0,0,1,0,0,"R7");
    apply(1,0,0,1,0,0,1,0,0,"R7");
    apply(0,1,0,1,1,0,0,0,0,"R8");
    apply(0,1,0,1,0,0,0,0,0,"R8");
    apply(0,1,0,1,0,0,0,0,1,"R11");
    apply(0,1,0,1,0,0,0,1,1,"R11");
    apply(0,1,0,1,0,0,0,0,0,"R11");
    apply(0,1,1,1,0,0,0,0,0,"R11");
    apply(0,1,0,1,0,0,0,0,0,"R11");

    // R10: measure the dead gap on a live polarity flip
    apply(1,0,0,1,0,0,0,0,0,"R10");
    @(negedge clk);
    pol_a = 1'b0;
    offs = 0;
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (hs_a && ls_a) check("R10 overlap", {hs_a, ls_a, 3'b000}, 5'b01000);
      if (ls_a) begin seen = 1'b1; break; end
      if (!hs_a) offs++;
    end
    check("R10 gap", {seen, 4'(offs)}, {1'b1, 4'(BBM)});

    for (int i = 0; i < 300; i++) begin
      logic [8:0] r;
      r = 9'($urandom);
      apply(r[0], r[1], ($urandom % 4) == 0, ($urandom % 5) != 0,
            ($urandom % 10) == 0, ($urandom % 16) == 0, r[2],
            ($urandom % 16) == 0, ($urandom % 12) == 0, "random R1 R5 R6");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule